// File: doc/BRIEF.md
# Dual-Issue Instruction Fetch Front End

This block sits at the front of a two-wide pipelined processor. It requests instructions in aligned pairs from an instruction memory port. Each returned pair goes into a two-entry fetch pair buffer. From there the instructions move into two decode buffers: the left one holds the older instruction and the right one the younger. The decode buffers feed a downstream issue queue in program order. Each cycle, one or two instructions are enqueued, depending on how many queue slots the queue reports free.

Each decode buffer refills from the fetch pair as soon as it becomes empty. Instructions therefore trickle into the queue as single slots open, and the front end never waits for room for a whole pair. When the left entry leaves and the right one stays, the right entry moves into the left position. This keeps the left buffer as the oldest.

A redirect (a taken branch or a flush) empties every buffer at once and reloads the program counter. A response that is still in flight when the redirect arrives is discarded when it returns. A redirect to the second word of a pair fetches the whole aligned pair, but only the second word enters the stream.

Top module: `dual_fetch_frontend`

## Requirements
- R1: While reset is asserted, neither enqueue slot is valid. In the first cycle after reset, a fetch request is presented at the reset address.
- R2: Every fetch address has its three low bits zero. Each accepted request (request and ready both high) moves the next fetch address forward by 8 bytes, however many instructions the queue has taken.
- R3: While a request is presented and ready is low, the request and its address stay unchanged in the next cycle unless a redirect arrives. No buffered instruction is lost while it waits.
- R4: A new request is presented only when the fetch pair buffer is empty and no response is outstanding. At most one request is outstanding at a time.
- R5: After a redirect to an address whose bit 2 is set, the aligned pair is fetched. Only its upper word (address + 4) enters the stream; the lower word (data bits 31:0) is dropped.
- R6: Enqueued instructions form a gap-free, duplicate-free sequence of addresses rising by 4 from the reset address or from the last redirect target. Each enqueued word equals the memory word at its address: the lower data word is the pair's base address and the upper word is base + 4.
- R7: The number of instructions enqueued in a cycle is the smaller of the number held in the decode buffers and the free-slot count. A free-slot code of 3 counts as 2.
- R8: The second enqueue slot is valid only together with the first. The first slot always carries the older instruction. With one free slot, the left entry is enqueued and the right one waits.
- R9: In a redirect cycle nothing is enqueued and no request is presented. A response outstanding at the redirect never reaches the stream. The next enqueued address is the redirect target.
- R10: A decode buffer that empties in a cycle is refilled in that same cycle from the fetch pair buffer. An instruction that arrives in a response can therefore be enqueued two cycles after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_req | output | 1 | Fetch request valid |
| imem_addr | output | ADDR_W | 8-byte aligned pair address |
| imem_ready | input | 1 | Memory accepts the request this cycle |
| imem_rsp_valid | input | 1 | Response data valid |
| imem_rsp_data | input | 2*INSN_W | Pair data, lower word at the lower address |
| redirect | input | 1 | Flush and reload the program counter |
| redirect_pc | input | ADDR_W | Redirect target (word aligned) |
| q_free_slots | input | 2 | Free issue-queue slots (3 counts as 2) |
| enq0_valid | output | 1 | Older enqueue slot valid |
| enq0_insn | output | INSN_W | Older instruction |
| enq0_pc | output | ADDR_W | Older instruction address |
| enq1_valid | output | 1 | Younger enqueue slot valid |
| enq1_insn | output | INSN_W | Younger instruction |
| enq1_pc | output | ADDR_W | Younger instruction address |

## Verification
The hardest situation to reach from the ports is a redirect that lands while a response is still outstanding. It is hardest of all when that redirect goes to an odd word, because a wrongly accepted stale pair is then easy to mistake for a valid one. The bench's memory model returns responses after a varying latency, so scheduled and random redirects fall both on in-flight responses and on the very cycle a response returns. A second hard case is the right decode buffer waiting behind the left one while the fetch pair still holds a word. A long stretch with exactly one free queue slot holds the block in that state.

// File: rtl/fe_pkg.sv
package fe_pkg;

  // Treat the free-slot code 3 as two usable slots.
  function automatic logic [1:0] fe_clamp2(input logic [1:0] v);
    return (v == 2'd3) ? 2'd2 : v;
  endfunction

  function automatic logic [1:0] fe_min(input logic [1:0] a, input logic [1:0] b);
    return (a < b) ? a : b;
  endfunction

  // Number of set flags among two.
  function automatic logic [1:0] fe_pop2(input logic a, input logic b);
    return {1'b0, a} + {1'b0, b};
  endfunction

endpackage

// File: rtl/fe_fetch_ctrl.sv
module fe_fetch_ctrl #(
  parameter int ADDR_W = 32,
  parameter int PAIR_BYTES = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect_i,
  input  logic [ADDR_W-1:0] redirect_pc_i,
  input  logic              fb_empty_i,
  input  logic              mem_ready_i,
  input  logic              mem_rsp_valid_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              fire_o,
  output logic              load_o,
  output logic              load_odd_o,
  output logic [ADDR_W-1:0] load_pc_o
);
  localparam int OFS_W    = $clog2(PAIR_BYTES);
  localparam int SLOT_BIT = OFS_W - 1;

  function automatic logic [ADDR_W-1:0] pair_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] next_pair(input logic [ADDR_W-1:0] a);
    return pair_base(a) + ADDR_W'(PAIR_BYTES);
  endfunction

  logic [ADDR_W-1:0] pc_q, base_q;
  logic              pend_q, drop_q, odd_q;
  logic              rsp_take;

  assign mem_req_o  = !pend_q && fb_empty_i && !redirect_i;
  assign mem_addr_o = pair_base(pc_q);
  assign fire_o     = mem_req_o && mem_ready_i;
  assign rsp_take   = pend_q && mem_rsp_valid_i;
  assign load_o     = rsp_take && !drop_q && !redirect_i;
  assign load_odd_o = odd_q;
  assign load_pc_o  = base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= RESET_PC;
      base_q <= '0;
      pend_q <= 1'b0;
      drop_q <= 1'b0;
      odd_q  <= 1'b0;
    end else if (redirect_i) begin
      pc_q   <= redirect_pc_i;
      pend_q <= pend_q && !mem_rsp_valid_i;
      drop_q <= pend_q && !mem_rsp_valid_i;
    end else begin
      if (rsp_take) begin
        pend_q <= 1'b0;
        drop_q <= 1'b0;
      end
      if (fire_o) begin
        pend_q <= 1'b1;
        odd_q  <= pc_q[SLOT_BIT];
        base_q <= pair_base(pc_q);
        pc_q   <= next_pair(pc_q);
      end
    end
  end
endmodule

// File: rtl/fe_pair_buf.sv
module fe_pair_buf #(
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush_i,
  input  logic                load_i,
  input  logic                load_odd_i,
  input  logic [ADDR_W-1:0]   load_pc_i,
  input  logic [2*INSN_W-1:0] load_data_i,
  input  logic [1:0]          consume_i,
  output logic                empty_o,
  output logic                head_valid_o,
  output logic [INSN_W-1:0]   head_insn_o,
  output logic [ADDR_W-1:0]   head_pc_o,
  output logic                next_valid_o,
  output logic [INSN_W-1:0]   next_insn_o,
  output logic [ADDR_W-1:0]   next_pc_o
);
  localparam int NSLOT = 2;

  logic [NSLOT-1:0]  v_q;
  logic [INSN_W-1:0] insn_q [NSLOT];
  logic [ADDR_W-1:0] base_q;
  logic [NSLOT-1:0]  clr;

  // Per-slot clear: two consumed clears all, one clears the oldest valid slot.
  for (genvar s = 0; s < NSLOT; s++) begin : g_clr
    if (s == 0) begin : g_first
      assign clr[s] = (consume_i == 2'd2) || (consume_i == 2'd1 && v_q[0]);
    end else begin : g_second
      assign clr[s] = (consume_i == 2'd2) || (consume_i == 2'd1 && !v_q[0]);
    end
  end

  assign empty_o      = (v_q == '0);
  assign head_valid_o = |v_q;
  assign head_insn_o  = v_q[0] ? insn_q[0] : insn_q[1];
  assign head_pc_o    = v_q[0] ? base_q : base_q + ADDR_W'(INSN_BYTES);
  assign next_valid_o = &v_q;
  assign next_insn_o  = insn_q[1];
  assign next_pc_o    = base_q + ADDR_W'(INSN_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      v_q <= '0;
    end else if (load_i) begin
      for (int s = 0; s < NSLOT; s++) begin
        v_q[s]    <= !(load_odd_i && s == 0);
        insn_q[s] <= load_data_i[s*INSN_W +: INSN_W];
      end
      base_q <= load_pc_i;
    end else begin
      v_q <= v_q & ~clr;
    end
  end
endmodule

// File: rtl/fe_decode_pair.sv
module fe_decode_pair
  import fe_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [1:0]        free_i,
  input  logic              fb_head_valid_i,
  input  logic [INSN_W-1:0] fb_head_insn_i,
  input  logic [ADDR_W-1:0] fb_head_pc_i,
  input  logic              fb_next_valid_i,
  input  logic [INSN_W-1:0] fb_next_insn_i,
  input  logic [ADDR_W-1:0] fb_next_pc_i,
  output logic [1:0]        consume_o,
  output logic              out0_valid_o,
  output logic [INSN_W-1:0] out0_insn_o,
  output logic [ADDR_W-1:0] out0_pc_o,
  output logic              out1_valid_o,
  output logic [INSN_W-1:0] out1_insn_o,
  output logic [ADDR_W-1:0] out1_pc_o
);
  typedef struct packed {
    logic              v;
    logic [INSN_W-1:0] insn;
    logic [ADDR_W-1:0] pc;
  } ent_t;

  ent_t left_q, right_q, left_d, right_d, fb_head, fb_next;
  logic [1:0] held, n_out, rem, fb_cnt, take;

  assign fb_head = '{v: fb_head_valid_i, insn: fb_head_insn_i, pc: fb_head_pc_i};
  assign fb_next = '{v: fb_next_valid_i, insn: fb_next_insn_i, pc: fb_next_pc_i};

  always_comb begin
    held   = fe_pop2(left_q.v, right_q.v);
    n_out  = flush_i ? 2'd0 : fe_min(held, fe_clamp2(free_i));
    rem    = held - n_out;
    fb_cnt = fe_pop2(fb_head_valid_i, fb_next_valid_i);
    take   = flush_i ? 2'd0 : fe_min(2'd2 - rem, fb_cnt);
    left_d  = '0;
    right_d = '0;
    case (rem)
      2'd2: begin
        left_d  = left_q;
        right_d = right_q;
      end
      2'd1: begin
        left_d  = (n_out == 2'd1) ? right_q : left_q;
        right_d = fb_head;
        right_d.v = (take != 2'd0);
      end
      default: begin
        left_d    = fb_head;
        left_d.v  = (take != 2'd0);
        right_d   = fb_next;
        right_d.v = (take == 2'd2);
      end
    endcase
  end

  assign consume_o    = take;
  assign out0_valid_o = (n_out != 2'd0);
  assign out0_insn_o  = left_q.insn;
  assign out0_pc_o    = left_q.pc;
  assign out1_valid_o = (n_out == 2'd2);
  assign out1_insn_o  = right_q.insn;
  assign out1_pc_o    = right_q.pc;

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      left_q.v  <= 1'b0;
      right_q.v <= 1'b0;
    end else begin
      left_q  <= left_d;
      right_q <= right_d;
    end
  end
endmodule

// File: rtl/dual_fetch_frontend.sv
module dual_fetch_frontend #(
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                imem_req,
  output logic [ADDR_W-1:0]   imem_addr,
  input  logic                imem_ready,
  input  logic                imem_rsp_valid,
  input  logic [2*INSN_W-1:0] imem_rsp_data,
  input  logic                redirect,
  input  logic [ADDR_W-1:0]   redirect_pc,
  input  logic [1:0]          q_free_slots,
  output logic                enq0_valid,
  output logic [INSN_W-1:0]   enq0_insn,
  output logic [ADDR_W-1:0]   enq0_pc,
  output logic                enq1_valid,
  output logic [INSN_W-1:0]   enq1_insn,
  output logic [ADDR_W-1:0]   enq1_pc
);
  localparam int INSN_BYTES = INSN_W / 8;
  localparam int PAIR_BYTES = 2 * INSN_BYTES;

  // Named internal events, visible to the bound checker.
  logic              fetch_fire, rsp_load, rsp_odd, fb_empty;
  logic [ADDR_W-1:0] rsp_pc;
  logic [1:0]        fb_consume;
  logic              fb_hv, fb_nv;
  logic [INSN_W-1:0] fb_hi, fb_ni;
  logic [ADDR_W-1:0] fb_hp, fb_np;

  fe_fetch_ctrl #(.ADDR_W(ADDR_W), .PAIR_BYTES(PAIR_BYTES), .RESET_PC(RESET_PC)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .redirect_i(redirect), .redirect_pc_i(redirect_pc),
    .fb_empty_i(fb_empty), .mem_ready_i(imem_ready), .mem_rsp_valid_i(imem_rsp_valid),
    .mem_req_o(imem_req), .mem_addr_o(imem_addr), .fire_o(fetch_fire),
    .load_o(rsp_load), .load_odd_o(rsp_odd), .load_pc_o(rsp_pc)
  );

  fe_pair_buf #(.ADDR_W(ADDR_W), .INSN_W(INSN_W), .INSN_BYTES(INSN_BYTES)) u_fbuf (
    .clk(clk), .rst_n(rst_n), .flush_i(redirect),
    .load_i(rsp_load), .load_odd_i(rsp_odd), .load_pc_i(rsp_pc), .load_data_i(imem_rsp_data),
    .consume_i(fb_consume), .empty_o(fb_empty),
    .head_valid_o(fb_hv), .head_insn_o(fb_hi), .head_pc_o(fb_hp),
    .next_valid_o(fb_nv), .next_insn_o(fb_ni), .next_pc_o(fb_np)
  );

  fe_decode_pair #(.ADDR_W(ADDR_W), .INSN_W(INSN_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .flush_i(redirect), .free_i(q_free_slots),
    .fb_head_valid_i(fb_hv), .fb_head_insn_i(fb_hi), .fb_head_pc_i(fb_hp),
    .fb_next_valid_i(fb_nv), .fb_next_insn_i(fb_ni), .fb_next_pc_i(fb_np),
    .consume_o(fb_consume),
    .out0_valid_o(enq0_valid), .out0_insn_o(enq0_insn), .out0_pc_o(enq0_pc),
    .out1_valid_o(enq1_valid), .out1_insn_o(enq1_insn), .out1_pc_o(enq1_pc)
  );
endmodule

// File: rtl/fe_frontend_chk.sv
module fe_frontend_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              imem_req,
  input logic              imem_ready,
  input logic [ADDR_W-1:0] imem_addr,
  input logic              redirect,
  input logic [1:0]        q_free_slots,
  input logic              enq0_valid,
  input logic              enq1_valid,
  input logic [ADDR_W-1:0] enq0_pc,
  input logic [ADDR_W-1:0] enq1_pc,
  input logic              fetch_fire,
  input logic              rsp_load
);
  logic [1:0] enq_n, free_eff;
  assign enq_n    = {1'b0, enq0_valid} + {1'b0, enq1_valid};
  assign free_eff = (q_free_slots == 2'd3) ? 2'd2 : q_free_slots;

  // R2
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req |-> imem_addr[2:0] == 3'b000);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_fire |=> imem_addr == $past(imem_addr) + ADDR_W'(8));

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req && !imem_ready |=> $stable(imem_addr) && (imem_req || redirect));

  // R4
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_fire |=> !imem_req);

  // R4
  busy_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_load |=> !imem_req);

  // R7
  enq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enq_n <= free_eff);

  // R8
  slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enq1_valid |-> enq0_valid && enq1_pc == enq0_pc + ADDR_W'(4));

  // R9
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> !enq0_valid && !imem_req);
endmodule

bind dual_fetch_frontend fe_frontend_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .imem_req(imem_req), .imem_ready(imem_ready),
  .imem_addr(imem_addr), .redirect(redirect), .q_free_slots(q_free_slots),
  .enq0_valid(enq0_valid), .enq1_valid(enq1_valid), .enq0_pc(enq0_pc),
  .enq1_pc(enq1_pc), .fetch_fire(fetch_fire), .rsp_load(rsp_load)
);

// File: tb/dual_fetch_frontend_test.sv
module dual_fetch_frontend_test;
  localparam logic [31:0] RST_PC = 32'h0000_1000;
  localparam int NCYC = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_req, imem_ready = 1'b0, imem_rsp_valid = 1'b0;
  logic [31:0] imem_addr;
  logic [63:0] imem_rsp_data = '0;
  logic        redirect = 1'b0;
  logic [31:0] redirect_pc = '0;
  logic [1:0]  q_free_slots = '0;
  logic        enq0_valid, enq1_valid;
  logic [31:0] enq0_insn, enq0_pc, enq1_insn, enq1_pc;

  int tests = 0, fails = 0;

  dual_fetch_frontend #(.RESET_PC(RST_PC)) uut (
    .clk(clk), .rst_n(rst_n), .imem_req(imem_req), .imem_addr(imem_addr),
    .imem_ready(imem_ready), .imem_rsp_valid(imem_rsp_valid), .imem_rsp_data(imem_rsp_data),
    .redirect(redirect), .redirect_pc(redirect_pc), .q_free_slots(q_free_slots),
    .enq0_valid(enq0_valid), .enq0_insn(enq0_insn), .enq0_pc(enq0_pc),
    .enq1_valid(enq1_valid), .enq1_insn(enq1_insn), .enq1_pc(enq1_pc)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return {a[15:0] ^ 16'h3C5A, a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model state
  logic [31:0] fbq[$];
  logic [31:0] dbq[$];
  logic [31:0] m_pc, m_base, stream_pc;
  bit m_pend, m_drop, m_odd, odd_watch;
  int enq_total = 0;

  // Memory model state
  bit mem_busy = 0;
  int mem_wait = 0;
  logic [31:0] mem_addr = '0;

  initial begin
    repeat (3) begin
      @(negedge clk);
      #1;
      // R1: no enqueue while in reset
      chk(!enq0_valid && !enq1_valid, "R1", {enq0_valid, enq1_valid}, 0);
    end
    m_pc = RST_PC; m_pend = 0; m_drop = 0; m_odd = 0; m_base = 0;
    stream_pc = RST_PC; odd_watch = 0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: first request at the reset address
    chk(imem_req && imem_addr == RST_PC, "R1", imem_addr, RST_PC);

    for (int c = 0; c < NCYC; c++) begin
      bit redir, rdy, rsp;
      logic [31:0] tgt;
      logic [1:0] fr, fr_eff;
      bit exp_req;
      int n;
      if (c > 0) @(negedge clk);
      // Stimulus selection by phase
      rdy = ($urandom % 4) != 0;
      if (c >= 600 && c < 800) rdy = ($urandom % 10) == 0;
      fr = 2'($urandom % 4);
      if (c >= 400 && c < 600) fr = 2'd1;
      if (c >= 800 && c < 1200) fr = 2'd3;
      redir = ($urandom % 50) == 0;
      tgt = 32'h0000_4000 + {20'd0, 10'($urandom), 2'b00};
      if (c == 100) begin redir = 1; tgt = 32'h0000_2004; end
      if (c == 250) begin redir = 1; tgt = 32'h0000_3000; end
      if (c == 650) begin redir = 1; tgt = 32'h0000_5004; end
      rsp = mem_busy && mem_wait == 0;
      imem_ready = rdy;
      q_free_slots = fr;
      redirect = redir;
      redirect_pc = tgt;
      imem_rsp_valid = rsp;
      imem_rsp_data = {word_at(mem_addr + 32'd4), word_at(mem_addr)};
      #1;
      // Expected combinational outputs
      exp_req = !m_pend && fbq.size() == 0 && !redir;
      fr_eff = (fr == 2'd3) ? 2'd2 : fr;
      n = redir ? 0 : ((dbq.size() < int'(fr_eff)) ? dbq.size() : int'(fr_eff));
      // R4 / R9: request only with empty pair buffer, nothing outstanding, no redirect
      chk(imem_req == exp_req, redir ? "R9" : "R4", imem_req, exp_req);
      if (exp_req) chk(imem_addr == {m_pc[31:3], 3'b000}, "R2", imem_addr, {m_pc[31:3], 3'b000});
      // R7 / R8: enqueue count and slot order
      chk(enq0_valid == (n >= 1), (fr == 2'd1) ? "R8" : "R7", enq0_valid, n >= 1);
      chk(enq1_valid == (n == 2), (fr == 2'd3) ? "R7" : "R8", enq1_valid, n == 2);
      if (n >= 1) chk(enq0_pc == dbq[0], "R10", enq0_pc, dbq[0]);
      if (n == 2) chk(enq1_pc == dbq[1], "R8", enq1_pc, dbq[1]);
      // R6 / R5 / R9: independent stream check
      if (enq0_valid) begin
        chk(enq0_pc == stream_pc, odd_watch ? "R5" : "R6", enq0_pc, stream_pc);
        chk(enq0_insn == word_at(enq0_pc), "R6", enq0_insn, word_at(enq0_pc));
        stream_pc = stream_pc + 4; odd_watch = 0; enq_total++;
      end
      if (enq1_valid) begin
        chk(enq1_pc == stream_pc, "R6", enq1_pc, stream_pc);
        chk(enq1_insn == word_at(enq1_pc), "R6", enq1_insn, word_at(enq1_pc));
        stream_pc = stream_pc + 4; enq_total++;
      end
      // Model update (what the coming edge does)
      if (redir) begin
        if (m_pend) begin
          if (rsp) begin m_pend = 0; m_drop = 0; end
          else m_drop = 1;
        end
        m_pc = tgt;
        fbq.delete(); dbq.delete();
        stream_pc = tgt; odd_watch = tgt[2];
      end else begin
        for (int k = 0; k < n; k++) void'(dbq.pop_front());
        while (dbq.size() < 2 && fbq.size() > 0) dbq.push_back(fbq.pop_front());
        if (rsp && m_pend) begin
          if (!m_drop) begin
            if (!m_odd) fbq.push_back(m_base);
            fbq.push_back(m_base + 4);
          end
          m_pend = 0; m_drop = 0;
        end
        if (exp_req && rdy) begin
          m_pend = 1; m_odd = m_pc[2];
          m_base = {m_pc[31:3], 3'b000};
          m_pc = m_base + 8;
        end
      end
      // Memory model update
      if (rsp) mem_busy = 0;
      else if (mem_busy && mem_wait > 0) mem_wait--;
      if (imem_req && imem_ready) begin
        mem_busy = 1; mem_wait = $urandom % 3; mem_addr = imem_addr;
      end
    end
    // R6: the stream made progress
    chk(enq_total > 500, "R6", enq_total, 500);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule